// File: doc/BRIEF.md
# Oversampling Serial Transceiver with Watermark FIFOs

This block is a full-duplex asynchronous serial port. Each frame has one start bit, eight data bits sent least significant bit first, no parity, and one or two stop bits. The transmitter and the receiver run from one programmable baud divisor. A free-running tick generator produces a tick every `divisor + 1` clocks, and one bit lasts sixteen ticks. Each direction has its own enable. Transmit and receive can be active at the same time.

Software-side logic writes bytes into a small transmit FIFO. The transmitter drains that FIFO onto `txd`. The receiver synchronises `rxd` and looks for a start bit on each tick. It then takes three samples in the middle of every bit and keeps the value that at least two of them agree on. Each complete byte is pushed into a receive FIFO, which is read one byte per request.

Each FIFO drives a level flag against its own programmable watermark, so a controller can refill the transmit side or empty the receive side in bursts.

Top module: `uart_os16`

## Requirements
- R1: During and after synchronous reset, `txd` is 1 and both FIFOs are empty. `rd_valid` is 0. Within two clocks of reset release, `tx_irq` equals (0 < `tx_wmark`) and `rx_irq` is 0.
- R2: The transmitter and the receiver share one tick of period `divisor + 1` clocks, and each bit lasts 16 ticks. With `divisor` = 1 and with `divisor` = 2, a byte sent on `txd` and looped back to `rxd` is received intact.
- R3: A frame on `txd` has a start bit of 0, then data bits 0 to 7 in that order, then stop bits of 1. Every byte value from 0 to 255 survives a loopback from `txd` to `rxd`.
- R4: The receiver samples each bit at ticks 7, 8 and 9 after the start detection, and takes the value that at least two of the three samples share. A two-clock pulse of the opposite level in the middle of a data bit, with `divisor` = 2, does not change the received byte.
- R5: `two_stop` = 0 gives one stop bit and `two_stop` = 1 gives two. For back-to-back bytes, consecutive start-bit falling edges on `txd` lie (162 or 178 ticks) × (`divisor` + 1) clocks apart.
- R6: If the start bit is no longer low at its mid-bit vote, the receiver treats it as a glitch and returns to idle. A low pulse four ticks long produces no byte.
- R7: While `tx_enable` is 0, no new frame starts, `txd` stays 1 and the bytes already written stay in the transmit FIFO.
- R8: While `rx_enable` is 0, frames on `rxd` are ignored and nothing enters the receive FIFO.
- R9: One clock after the transmit FIFO count changes, `tx_irq` reflects (count < `tx_wmark`).
- R10: One clock after the receive FIFO count changes, `rx_irq` reflects (count > `rx_wmark`).
- R11: A byte received while the receive FIFO holds DEPTH (4) bytes is discarded. The bytes already stored are unchanged.
- R12: A pulse on `rd_req` gives `rd_valid` = 1 with the oldest byte on `rd_data` on the next clock. If the receive FIFO is empty, `rd_valid` stays 0.
- R13: Bytes written back to back are sent and received in order while the transmitter and the receiver are both busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | DIV_W (16) | Tick period minus one, in clocks |
| two_stop | input | 1 | 1 selects two transmitted stop bits |
| tx_enable | input | 1 | Allows the transmitter to start frames |
| rx_enable | input | 1 | Allows the receiver to accept frames |
| tx_wmark | input | CW (3) | Transmit watermark |
| rx_wmark | input | CW (3) | Receive watermark |
| wr_valid | input | 1 | Write strobe for the transmit FIFO |
| wr_data | input | W (8) | Byte to transmit |
| rd_req | input | 1 | Read strobe for the receive FIFO |
| rd_valid | output | 1 | `rd_data` holds a byte read on the previous clock |
| rd_data | output | W (8) | Received byte |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_irq | output | 1 | Transmit FIFO count is below `tx_wmark` |
| rx_irq | output | 1 | Receive FIFO count is above `rx_wmark` |

## Verification
The watermark flags follow a FIFO count change by one clock. `rd_valid` and `rd_data` follow `rd_req` by one clock. A received byte reaches the FIFO at the vote in the middle of its first stop bit, which is two synchroniser clocks plus up to one tick after the line itself. The bench drives inputs at falling edges and samples at falling edges. It waits at least two clocks before checking a flag, checks a read on the falling edge right after the request, and reads received bytes only after the whole frame plus idle time has passed. The stop-bit and divisor results are checked exactly, as the time between falling edges of `txd`, which both come from the same tick grid.

// File: rtl/uart_os16_pkg.sv
package uart_os16_pkg;
  localparam int OSR = 16;
  typedef enum logic [2:0] {TX_IDLE, TX_ARM, TX_START, TX_DATA, TX_STOP} tx_state_e;
endpackage

// File: rtl/uart_os16_tick.sv
module uart_os16_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= divisor) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_os16_fifo.sv
module uart_os16_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign push_ok = push && (count != CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_os16_tx.sv
module uart_os16_tx
  import uart_os16_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         enable,
  input  logic         two_stop,
  input  logic         empty,
  input  logic [W-1:0] rdata,
  output logic         pop,
  output logic         txd
);
  localparam int SW = $clog2(OSR);
  localparam int BW = $clog2(W);
  localparam logic [SW-1:0] SUB_LAST = SW'(OSR - 1);

  tx_state_e     st;
  logic [SW-1:0] sub;
  logic [BW-1:0] bitn;
  logic [W-1:0]  shr;
  logic          extra;

  assign pop = tick && (st == TX_IDLE) && enable && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= TX_IDLE;
      txd   <= 1'b1;
      sub   <= '0;
      bitn  <= '0;
      shr   <= '0;
      extra <= 1'b0;
    end else if (tick) begin
      case (st)
        TX_IDLE: if (pop) st <= TX_ARM;
        TX_ARM: begin
          shr <= rdata;
          txd <= 1'b0;
          sub <= '0;
          st  <= TX_START;
        end
        TX_START: begin
          sub <= sub + SW'(1);
          if (sub == SUB_LAST) begin
            txd  <= shr[0];
            shr  <= shr >> 1;
            bitn <= '0;
            st   <= TX_DATA;
          end
        end
        TX_DATA: begin
          sub <= sub + SW'(1);
          if (sub == SUB_LAST) begin
            if (bitn == BW'(W - 1)) begin
              txd   <= 1'b1;
              extra <= two_stop;
              st    <= TX_STOP;
            end else begin
              txd  <= shr[0];
              shr  <= shr >> 1;
              bitn <= bitn + BW'(1);
            end
          end
        end
        TX_STOP: begin
          sub <= sub + SW'(1);
          if (sub == SUB_LAST) begin
            if (extra) extra <= 1'b0;
            else       st    <= TX_IDLE;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_os16_rx.sv
module uart_os16_rx
  import uart_os16_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         enable,
  input  logic         rxd_s,
  output logic         push,
  output logic [W-1:0] data
);
  localparam int SW  = $clog2(OSR);
  localparam int BW  = $clog2(W + 2);
  localparam int MID = OSR / 2;

  logic          busy, s0, s1, vote;
  logic [SW-1:0] sub;
  logic [BW-1:0] bitn;

  assign vote = (s0 & s1) | (s0 & rxd_s) | (s1 & rxd_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sub  <= '0;
      bitn <= '0;
      s0   <= 1'b1;
      s1   <= 1'b1;
      data <= '0;
      push <= 1'b0;
    end else begin
      push <= 1'b0;
      if (!enable) begin
        busy <= 1'b0;
      end else if (tick) begin
        if (!busy) begin
          if (!rxd_s) begin
            busy <= 1'b1;
            sub  <= SW'(1);
            bitn <= '0;
          end
        end else begin
          sub <= sub + SW'(1);
          if (sub == SW'(OSR - 1)) bitn <= bitn + BW'(1);
          if (sub == SW'(MID - 1)) s0 <= rxd_s;
          if (sub == SW'(MID))     s1 <= rxd_s;
          if (sub == SW'(MID + 1)) begin
            if (bitn == '0) begin
              if (vote) busy <= 1'b0;
            end else if (bitn == BW'(W + 1)) begin
              busy <= 1'b0;
              push <= vote;
            end else begin
              data <= {vote, data[W-1:1]};
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_os16.sv
module uart_os16 #(
  parameter int DIV_W = 16,
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  input  logic             two_stop,
  input  logic             tx_enable,
  input  logic             rx_enable,
  input  logic [CW-1:0]    tx_wmark,
  input  logic [CW-1:0]    rx_wmark,
  input  logic             wr_valid,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_req,
  output logic             rd_valid,
  output logic [W-1:0]     rd_data,
  input  logic             rxd,
  output logic             txd,
  output logic             tx_irq,
  output logic             rx_irq
);
  logic          tick, tx_pop, rx_push, rxd_s;
  logic [1:0]    rx_sync;
  logic [W-1:0]  tx_rdata, rx_byte;
  logic [CW-1:0] tx_count, rx_count;

  always_ff @(posedge clk) begin
    if (rst) rx_sync <= '1;
    else     rx_sync <= {rx_sync[0], rxd};
  end
  assign rxd_s = rx_sync[1];

  uart_os16_tick #(.DIV_W(DIV_W)) i_tick (
    .clk(clk), .rst(rst), .divisor(divisor), .tick(tick)
  );

  uart_os16_fifo #(.W(W), .DEPTH(DEPTH)) i_tx_fifo (
    .clk(clk), .rst(rst), .push(wr_valid), .wdata(wr_data),
    .pop(tx_pop), .rdata(tx_rdata), .count(tx_count)
  );

  uart_os16_tx #(.W(W)) i_tx (
    .clk(clk), .rst(rst), .tick(tick), .enable(tx_enable), .two_stop(two_stop),
    .empty(tx_count == '0), .rdata(tx_rdata), .pop(tx_pop), .txd(txd)
  );

  uart_os16_rx #(.W(W)) i_rx (
    .clk(clk), .rst(rst), .tick(tick), .enable(rx_enable), .rxd_s(rxd_s),
    .push(rx_push), .data(rx_byte)
  );

  uart_os16_fifo #(.W(W), .DEPTH(DEPTH)) i_rx_fifo (
    .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_byte),
    .pop(rd_req), .rdata(rd_data), .count(rx_count)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_req && (rx_count != '0);
  end

  always_ff @(posedge clk) begin
    tx_irq <= tx_count < tx_wmark;
    rx_irq <= rx_count > rx_wmark;
  end
endmodule

// File: rtl/uart_os16_chk.sv
module uart_os16_chk #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_enable,
  input logic          rx_enable,
  input logic          rd_req,
  input logic          rd_valid,
  input logic          tx_irq,
  input logic          rx_irq,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_wmark,
  input logic [CW-1:0] rx_wmark
);
  a_r9_tx_level: assert property (@(posedge clk) disable iff (rst)
    tx_irq == ($past(tx_count) < $past(tx_wmark)));

  a_r10_rx_level: assert property (@(posedge clk) disable iff (rst)
    rx_irq == ($past(rx_count) > $past(rx_wmark)));

  a_r12_read_follows_req: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req));

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

  a_r7_no_drain_when_off: assert property (@(posedge clk) disable iff (rst)
    !$past(tx_enable) |-> tx_count >= $past(tx_count));

  a_r8_no_fill_when_off: assert property (@(posedge clk) disable iff (rst)
    (!$past(rx_enable) && !$past(rx_enable, 2)) |-> rx_count <= $past(rx_count));
endmodule

bind uart_os16 uart_os16_chk #(.DEPTH(DEPTH)) i_uart_os16_chk (
  .clk(clk), .rst(rst), .tx_enable(tx_enable), .rx_enable(rx_enable),
  .rd_req(rd_req), .rd_valid(rd_valid), .tx_irq(tx_irq), .rx_irq(rx_irq),
  .tx_count(tx_count), .rx_count(rx_count), .tx_wmark(tx_wmark), .rx_wmark(rx_wmark)
);

// File: tb/test_uart_os16.sv
`timescale 1ns/1ps
module test_uart_os16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] divisor = '0;
  logic        two_stop = 1'b0, tx_enable = 1'b0, rx_enable = 1'b0;
  logic [2:0]  tx_wmark = 3'd1, rx_wmark = 3'd0;
  logic        wr_valid = 1'b0, rd_req = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_valid, txd, tx_irq, rx_irq, rxd;
  logic [7:0]  rd_data;
  logic        loop = 1'b0, drv = 1'b1;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;
  assign rxd = loop ? txd : drv;

  uart_os16 i_uart_os16 (
    .clk(clk), .rst(rst), .divisor(divisor), .two_stop(two_stop),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .tx_wmark(tx_wmark),
    .rx_wmark(rx_wmark), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .rxd(rxd), .txd(txd), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] v);
    wr_valid = 1'b1; wr_data = v; cyc(1);
    wr_valid = 1'b0; cyc(1);
  endtask

  task automatic read_byte(output logic vld, output logic [7:0] v);
    rd_req = 1'b1; cyc(1);
    rd_req = 1'b0; vld = rd_valid; v = rd_data;
    cyc(1);
  endtask

  task automatic send_frame(input logic [7:0] v, input int spike);
    int bt = 16 * (int'(divisor) + 1);
    drv = 1'b0; cyc(bt);
    for (int i = 0; i < 8; i++) begin
      drv = v[i];
      if (i == spike) begin
        cyc(bt / 2 - 1); drv = ~v[i]; cyc(2); drv = v[i]; cyc(bt - bt / 2 - 1);
      end else cyc(bt);
    end
    drv = 1'b1; cyc(3 * bt);
  endtask

  task automatic gap_test(input int d, input logic ts, input int exp_clk, input string req);
    time t1, t2;
    logic vld; logic [7:0] v;
    tx_enable = 1'b0; divisor = 16'(d); two_stop = ts; cyc(4);
    write_byte(8'hFF); write_byte(8'hFF);
    tx_enable = 1'b1;
    @(negedge txd); t1 = $time;
    @(negedge txd); t2 = $time;
    chk(req, int'((t2 - t1) / 4), exp_clk);
    cyc(200 * (d + 1));
    for (int k = 0; k < 2; k++) begin
      read_byte(vld, v);
      chk("R2 loopback byte valid at shared divisor", vld, 1);
      chk("R2 loopback byte value at shared divisor", v, 8'hFF);
    end
  endtask

  initial begin
    logic vld; logic [7:0] v;
    logic [7:0] burst [4] = '{8'h3C, 8'hA5, 8'h01, 8'h80};
    logic [7:0] rxv [5] = '{8'h5A, 8'hC3, 8'h0F, 8'h96, 8'h77};
    int spk [5] = '{1, 4, 7, 0, 3};
    int low;

    cyc(5); rst = 1'b0; cyc(3);
    // R1 reset state
    chk("R1 txd idle high", txd, 1);
    chk("R1 tx_irq after reset", tx_irq, 1);
    chk("R1 rx_irq after reset", rx_irq, 0);
    read_byte(vld, v);
    chk("R1 R12 read of empty FIFO", vld, 0);

    // R9 and R7: transmit watermark sweep with the transmitter held off
    foreach (spk[w]) begin
      if (w < 2) begin
        tx_wmark = (w == 0) ? 3'd1 : 3'd3;
        tx_enable = 1'b0; cyc(3);
        chk("R9 tx_irq at count 0", tx_irq, (0 < tx_wmark) ? 1 : 0);
        low = 0;
        for (int c = 1; c <= 4; c++) begin
          write_byte(8'(c));
          cyc(1);
          if (txd == 1'b0) low++;
          chk("R9 tx_irq versus count", tx_irq, (c < int'(tx_wmark)) ? 1 : 0);
        end
        for (int k = 0; k < 400; k++) begin
          cyc(1);
          if (txd == 1'b0) low++;
        end
        chk("R7 txd low samples while disabled", low, 0);
        chk("R7 bytes retained while disabled", tx_irq, 0);
        divisor = 16'd0; tx_enable = 1'b1; cyc(800);
        tx_enable = 1'b0; cyc(3);
        chk("R9 tx_irq after drain", tx_irq, 1);
      end
    end

    // R3: every byte value through a loopback
    loop = 1'b1; rx_enable = 1'b1; tx_enable = 1'b1; divisor = 16'd0; tx_wmark = 3'd1;
    for (int b = 0; b < 256; b++) begin
      write_byte(8'(b));
      cyc(200);
      read_byte(vld, v);
      chk("R3 loopback valid", vld, 1);
      chk("R3 loopback value", v, b);
    end

    // R13: back-to-back bytes with both directions busy
    foreach (burst[i]) write_byte(burst[i]);
    cyc(4 * 180 + 100);
    foreach (burst[i]) begin
      read_byte(vld, v);
      chk("R13 burst valid", vld, 1);
      chk("R13 burst order", v, burst[i]);
    end

    // R5 and R2: frame spacing on the shared tick grid
    gap_test(1, 1'b0, 162 * 2, "R5 one stop bit spacing divisor 1");
    gap_test(1, 1'b1, 178 * 2, "R5 two stop bits spacing divisor 1");
    gap_test(2, 1'b0, 162 * 3, "R2 spacing follows divisor 2");

    // R4, R10, R11: direct frames with mid-bit spikes
    tx_enable = 1'b0; loop = 1'b0; two_stop = 1'b0; divisor = 16'd2; rx_wmark = 3'd1; cyc(20);
    for (int i = 0; i < 5; i++) begin
      send_frame(rxv[i], spk[i]);
      chk("R10 rx_irq versus count", rx_irq, ((i < 4 ? i + 1 : 4) > 1) ? 1 : 0);
    end
    rx_wmark = 3'd3; cyc(2);
    for (int i = 0; i < 4; i++) begin
      read_byte(vld, v);
      chk("R4 R11 stored byte valid", vld, 1);
      chk("R4 R11 stored byte value", v, rxv[i]);
      chk("R10 rx_irq after read", rx_irq, ((3 - i) > 3) ? 1 : 0);
    end
    read_byte(vld, v);
    chk("R11 byte arriving when full was dropped", vld, 0);

    // R6: short start pulse is rejected
    drv = 1'b0; cyc(4 * 3); drv = 1'b1; cyc(600);
    send_frame(8'h24, -1);
    read_byte(vld, v);
    chk("R6 frame after glitch valid", vld, 1);
    chk("R6 first byte is the real frame", v, 8'h24);
    read_byte(vld, v);
    chk("R6 glitch produced no byte", vld, 0);

    // R8: receiver disabled
    rx_enable = 1'b0; rx_wmark = 3'd0; cyc(4);
    send_frame(8'h99, -1);
    chk("R8 rx_irq with receiver off", rx_irq, 0);
    read_byte(vld, v);
    chk("R8 nothing stored with receiver off", vld, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1..all actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule